// File: doc/BRIEF.md
# Watchdog Multi-Key Reload Request Tracker

This block decides when a watchdog countdown may be refreshed. Software owns up to eight independent request ports. A port takes part in the decision only when its bit is set in an enable mask. Writing the secret 32-bit key to an enabled port marks that port as having asked for a refresh. When every enabled port has asked, the tracker raises a single-cycle grant toward the counter core and forgets all requests in the same clock edge. A new refresh then needs another full round of keys.

A per-port status vector shows which enabled ports have not yet asked. Software can use it to find the task that failed to check in. The mask can be changed only while the watchdog is stopped, and key writes count only while it runs. This keeps a runaway program from narrowing the set of ports it must satisfy.

Top module: `reload_key_tracker`

## Requirements
- R1: After reset the mask reads 0x01, the status reads 0x01 and the grant is low.
- R2: While `wdt_running` is high, writing the key 0x6E524635 to port `key_idx` with that port enabled records a request. The status bit with the same index as the port then reads 0 from the next cycle.
- R3: A key write of any value other than 0x6E524635 changes neither the status nor the grant.
- R4: The write that completes the last missing enabled request raises `reload_grant` for exactly the next cycle. In that same cycle every request flag is already clear, so the status equals the mask.
- R5: Status bit i is 1 exactly when mask bit i is 1 and port i holds no request; otherwise it is 0.
- R6: A mask write takes effect on the next cycle only while `wdt_running` is low. While `wdt_running` is high, the mask holds its value.
- R7: While `wdt_running` is low, key writes are ignored, no grant is issued, and all request flags are cleared by the next cycle.
- R8: With the mask at 0x00, no grant is ever produced.
- R9: A correct key written to a port whose mask bit is 0 has no effect on the status or the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_running | input | 1 | Watchdog counter is running |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 8 | New enable mask, bit i enables port i |
| key_we | input | 1 | Write strobe for a request port |
| key_idx | input | 3 | Index of the request port written |
| key_wdata | input | 32 | Data written to the request port |
| reload_grant | output | 1 | One-cycle reload permission to the counter core |
| enable_mask | output | 8 | Current enable mask |
| pending | output | 8 | Bit i: port i enabled and not yet requested |

## Verification
Each result is due exactly one clock edge after the stimulus that causes it. A key or mask write presented in one cycle shows up in `pending`, `enable_mask` and `reload_grant` after the following rising edge, and a grant lasts one cycle. The bench drives every input on the falling edge and lets one rising edge pass. It then samples all three outputs shortly afterwards and compares them with a model state that it advanced once for that same edge, so every comparison lines up with the single register stage.

// File: rtl/reload_key_tracker.sv
module reload_key_tracker #(
  parameter int          NPORTS   = 8,
  parameter int          KEY_W    = 32,
  parameter logic [31:0] KEY      = 32'h6E524635,
  parameter logic [7:0]  MASK_RST = 8'h01,
  localparam int         IDX_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_running,
  input  logic              mask_we,
  input  logic [NPORTS-1:0] mask_wdata,
  input  logic              key_we,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic [KEY_W-1:0]  key_wdata,
  output logic              reload_grant,
  output logic [NPORTS-1:0] enable_mask,
  output logic [NPORTS-1:0] pending
);

  logic [NPORTS-1:0] req_q;
  logic [NPORTS-1:0] hit;
  logic [NPORTS-1:0] req_nxt;
  logic              key_ok;
  logic              all_in;

  assign key_ok = key_we && wdt_running && (key_wdata == KEY[KEY_W-1:0]);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign hit[i] = key_ok && (key_idx == IDX_W'(i)) && enable_mask[i];
  end

  assign req_nxt = req_q | hit;
  assign all_in  = (enable_mask != '0) && ((req_nxt & enable_mask) == enable_mask);
  assign pending = enable_mask & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_mask <= MASK_RST[NPORTS-1:0];
    end else if (mask_we && !wdt_running) begin
      enable_mask <= mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q        <= '0;
      reload_grant <= 1'b0;
    end else if (!wdt_running) begin
      req_q        <= '0;
      reload_grant <= 1'b0;
    end else if (all_in) begin
      req_q        <= '0;
      reload_grant <= 1'b1;
    end else begin
      req_q        <= req_nxt;
      reload_grant <= 1'b0;
    end
  end

endmodule

module reload_key_tracker_chk #(
  parameter int          NPORTS = 8,
  parameter int          KEY_W  = 32,
  parameter logic [31:0] KEY    = 32'h6E524635,
  parameter int          IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_running,
  input logic              key_we,
  input logic [KEY_W-1:0]  key_wdata,
  input logic              reload_grant,
  input logic [NPORTS-1:0] enable_mask,
  input logic [NPORTS-1:0] pending
);

  // R4 R7 R8
  grant_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_grant |-> ($past(wdt_running) && enable_mask != '0));

  // R4
  grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_grant |-> (pending == enable_mask));

  // R6
  mask_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wdt_running) |-> $stable(enable_mask));

  // R7
  stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wdt_running) |-> (pending == enable_mask && !reload_grant));

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wdt_running && key_we && key_wdata != KEY[KEY_W-1:0]) |-> ($stable(pending) && !reload_grant));

  // R2 R5
  monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wdt_running) && !reload_grant) |-> ((pending & ~$past(pending)) == '0));

endmodule

bind reload_key_tracker reload_key_tracker_chk #(
  .NPORTS(NPORTS), .KEY_W(KEY_W), .KEY(KEY), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_running(wdt_running), .key_we(key_we),
  .key_wdata(key_wdata), .reload_grant(reload_grant),
  .enable_mask(enable_mask), .pending(pending)
);

// File: tb/reload_key_tracker_bench.sv
module reload_key_tracker_bench;
  localparam logic [31:0] KEY = 32'h6E524635;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_running = 1'b0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic        key_we = 1'b0;
  logic [2:0]  key_idx = '0;
  logic [31:0] key_wdata = '0;
  logic        reload_grant;
  logic [7:0]  enable_mask;
  logic [7:0]  pending;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_mask;
  logic [7:0] m_req;
  logic       m_grant;

  always #10 clk = ~clk;

  reload_key_tracker u_reload_key_tracker (
    .clk(clk), .rst_n(rst_n), .wdt_running(wdt_running),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .key_we(key_we), .key_idx(key_idx), .key_wdata(key_wdata),
    .reload_grant(reload_grant), .enable_mask(enable_mask), .pending(pending)
  );

  function automatic logic [7:0] exp_pending(logic [7:0] m, logic [7:0] r);
    return m & ~r;
  endfunction

  function automatic bit completes(logic [7:0] m, logic [7:0] r);
    return (m != 8'h00) && ((r & m) == m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " R4 grant"}, 32'(reload_grant), 32'(m_grant));
    check({tag, " R5 pending"}, 32'(pending), 32'(exp_pending(m_mask, m_req)));
    check({tag, " R6 mask"}, 32'(enable_mask), 32'(m_mask));
  endtask

  task automatic step(input bit run, input bit mwe, input logic [7:0] md,
                      input bit kwe, input logic [2:0] ki, input logic [31:0] kd,
                      input string tag);
    logic [7:0] nreq;
    @(negedge clk);
    wdt_running = run; mask_we = mwe; mask_wdata = md;
    key_we = kwe; key_idx = ki; key_wdata = kd;
    @(posedge clk);
    nreq = m_req;
    if (kwe && run && kd == KEY && m_mask[ki]) nreq[ki] = 1'b1;
    if (!run) begin
      m_req = '0; m_grant = 1'b0;
      if (mwe) m_mask = md;
    end else if (completes(m_mask, nreq)) begin
      m_req = '0; m_grant = 1'b1;
    end else begin
      m_req = nreq; m_grant = 1'b0;
    end
    #2;
    compare_all(tag);
  endtask

  initial begin
    m_mask = 8'h01; m_req = '0; m_grant = 1'b0;
    #45;
    check("R1 grant", 32'(reload_grant), 32'h0);
    check("R1 pending", 32'(pending), 32'h01);
    check("R1 mask", 32'(enable_mask), 32'h01);
    rst_n = 1'b1;

    // R7: keys while stopped are ignored
    step(0, 0, 0, 1, 0, KEY, "R7 stopped key");
    // R6: mask written while stopped
    step(0, 1, 8'h05, 0, 0, 0, "R6 mask set");
    step(1, 0, 0, 0, 0, 0, "R6 start");
    // R6: mask write ignored while running
    step(1, 1, 8'hFF, 0, 0, 0, "R6 mask locked");
    // R3: wrong key
    step(1, 0, 0, 1, 0, KEY ^ 32'h1, "R3 wrong key");
    // R9: correct key to disabled port 1
    step(1, 0, 0, 1, 1, KEY, "R9 disabled port");
    // R2: port 0 requests
    step(1, 0, 0, 1, 0, KEY, "R2 port0");
    check("R2 pending bit0", 32'(pending), 32'h04);
    // R4: port 2 completes
    step(1, 0, 0, 1, 2, KEY, "R4 complete");
    check("R4 grant high", 32'(reload_grant), 32'h1);
    step(1, 0, 0, 0, 0, 0, "R4 one cycle");
    check("R4 grant low", 32'(reload_grant), 32'h0);
    // R7: stop clears partial requests
    step(1, 0, 0, 1, 2, KEY, "R7 partial");
    step(0, 0, 0, 0, 0, 0, "R7 stop clears");
    // R8: zero mask
    step(0, 1, 8'h00, 0, 0, 0, "R8 zero mask");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 1, 3'(i), KEY, "R8 no grant");
    step(0, 1, 8'h80, 0, 0, 0, "R8 mask");
    step(1, 0, 0, 1, 7, KEY, "R4 top port");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit run, mwe, kwe;
      logic [7:0] md;
      logic [2:0] ki;
      logic [31:0] kd;
      run = ($urandom_range(0, 19) != 0);
      mwe = ($urandom_range(0, 3) == 0);
      md  = 8'($urandom) & 8'($urandom);
      kwe = ($urandom_range(0, 3) != 0);
      ki  = 3'($urandom_range(0, 7));
      kd  = ($urandom_range(0, 9) < 7) ? KEY : $urandom;
      step(run, mwe, md, kwe, ki, kd, "R2 R5 random");
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'h1d2c));
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule